// File: doc/BRIEF.md
# Character Overlay Attribute Mixer with Two Output Channels

This block sits behind the font lookup of an on-screen text overlay. Every clock it takes one pixel of the scan stream. Each pixel carries a font bit, a per-character attribute bit, a grid-membership flag and the index of the text row it belongs to. The block turns that stream into two output channels, and each channel has a foreground (character) signal and a keying (blank) signal.

On the way it applies reverse video, blinking, an outline halo and the choice of blank-signal content. Blink timing comes from the field-rate sync. A per-row enable mask steers each text row onto channel two. Channel one either carries every row or only the rows that channel two does not.

The halo looks at all four neighbours of a pixel. To see the pixel below, the block therefore holds two scan lines of the stream in memories that infer as block RAM. As a result its outputs trail the input stream by a fixed number of cycles.

Top module: `osd_mix_top`

## Requirements
- R1: A synchronous active-high reset clears all four outputs and the blink phase, so blinking characters are visible after reset. The outputs stay low until 2·LINE_PIX+2 clock edges have passed since reset was released.
- R2: Outputs are registered. The result for the stream pixel sampled at clock edge e appears after edge e+LINE_PIX+2. Control inputs take effect at the output edge itself.
- R3: All four outputs are low for a pixel whose grid flag is 0, and for every pixel while the display enable is 0.
- R4: For a character with attribute bit 0, the foreground equals the font pixel. Reverse, blink and the halo on that pixel are then decided only by the font and the controls.
- R5: For a character with attribute 1 while the reverse enable is 1, the foreground is the inverted font pixel, and the blank data is 1 over the whole cell.
- R6: For a character with attribute 1, blink enable 1 and reverse enable 0, the foreground and the halo are both 0 while the blink phase is 1.
- R7: For a character with attribute 1, blink enable 1 and reverse enable 1, the cell shows reversed while the blink phase is 0 and normal while it is 1.
- R8: The blink phase toggles when a falling edge of the active-low field sync has been counted 15 times (slow select 0) or 30 times (slow select 1). Counting starts at reset or at the previous toggle. A fall is a sample of 0 directly after a sample of 1.
- R9: With the halo enabled, a pixel whose own font bit is 0 gets blank data 1 when any of its four neighbours is lit. The neighbours are the stream pixels one position and LINE_PIX positions before and after it, and a neighbour counts as lit when its font bit and its grid flag are both 1.
- R10: With blank-only select 0, the blank output is the blank data OR'd with the foreground. With blank-only select 1, the blank output is the blank data alone.
- R11: Channel two carries row r only when bit r of the line-enable mask is 1. Rows at or above ROWS appear on neither channel.
- R12: With the exclusive select 0, channel one carries every row. With the exclusive select 1, channel one carries only the rows whose line-enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_i | input | 1 | Synchronous reset, active high |
| font_pix_i | input | 1 | Font bit of the current pixel |
| attr_i | input | 1 | Attribute bit of the character the pixel belongs to |
| in_grid_i | input | 1 | Pixel lies inside the text grid |
| row_i | input | ROW_W | Text row index of the pixel |
| vsync_n_i | input | 1 | Field sync, active low, used for blink timing |
| dsp_i | input | 1 | Display enable |
| rv_i | input | 1 | Reverse video enable |
| blink_en_i | input | 1 | Blink enable |
| blink_slow_i | input | 1 | Blink period select (1 = long) |
| border_en_i | input | 1 | Halo enable |
| blank_only_i | input | 1 | Blank output carries blank data only |
| sys1_excl_i | input | 1 | Channel one shows only rows not routed to channel two |
| line_en_i | input | ROWS | Per-row enable for channel two |
| cha1_o | output | 1 | Channel one foreground |
| blk1_o | output | 1 | Channel one blank |
| cha2_o | output | 1 | Channel two foreground |
| blk2_o | output | 1 | Channel two blank |

## Verification
A fault in the line memories shows up first on the halo. A stale pointer or an off-by-one depth moves the halo sideways or vertically, and the misplaced blank bits appear on the ports LINE_PIX+2 cycles after the offending pixel enters the block.

A wrong blink count is visible on the ports only when a field fall crosses the toggle threshold. The bench therefore sends exactly 14, 15 and 30 falls and compares every output cycle after each run.

A wrong row decode shows up within a single scan line, as foreground on the wrong channel or on both channels in exclusive mode.

// File: rtl/osd_mix_pkg.sv
package osd_mix_pkg;

  // One pixel of the scan stream as it travels through the line memories.
  typedef struct packed {
    logic attr;
    logic ingrid;
    logic font;
  } osd_cell_t;

  // A pixel counts as lit only when its font bit is set inside the grid.
  function automatic logic eff_pix(osd_cell_t c);
    return c.font & c.ingrid;
  endfunction

endpackage

// File: rtl/osd_line_delay.sv
// Fixed delay of DEPTH cycles built on a read-first memory.
module osd_line_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] ptr;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ptr <= '0;
    end else if (ptr == AW'(DEPTH - 1)) begin
      ptr <= '0;
    end else begin
      ptr <= ptr + 1'b1;
    end
  end

  // Read before write at the same address gives exactly DEPTH cycles.
  always_ff @(posedge clk_i) begin
    q_o      <= mem[ptr];
    mem[ptr] <= d_i;
  end
endmodule

// File: rtl/osd_blink_timer.sv
// Counts falls of the field sync and flips the blink phase every half period.
module osd_blink_timer #(
  parameter int SLOW_HALF = 30,
  parameter int FAST_HALF = 15
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic vsync_n_i,
  input  logic slow_i,
  output logic phase_o
);
  localparam int CW = $clog2(SLOW_HALF + 1);

  logic          vs_d;
  logic          fall;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign fall = vs_d & ~vsync_n_i;
  assign last = slow_i ? CW'(SLOW_HALF - 1) : CW'(FAST_HALF - 1);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      vs_d    <= 1'b0;
      cnt     <= '0;
      phase_o <= 1'b0;
    end else begin
      vs_d <= vsync_n_i;
      if (fall) begin
        if (cnt >= last) begin
          cnt     <= '0;
          phase_o <= ~phase_o;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/osd_cell_shade.sv
// Per-pixel attribute logic: reverse video, blink and halo.
module osd_cell_shade (
  input  logic       font_i,
  input  logic       attr_i,
  input  logic       phase_i,
  input  logic       rv_en_i,
  input  logic       blink_en_i,
  input  logic       border_en_i,
  input  logic       blank_only_i,
  input  logic [3:0] nb_i,
  output logic       cha_o,
  output logic       blk_o
);
  logic rev, blinking, hide, flip, fg, halo, bdata;

  always_comb begin
    rev      = attr_i & rv_en_i;
    blinking = attr_i & blink_en_i;
    hide     = blinking & ~rev & phase_i;
    flip     = rev & ~(blinking & phase_i);
    fg       = hide ? 1'b0 : (flip ? ~font_i : font_i);
    halo     = border_en_i & ~font_i & (|nb_i) & ~hide;
    bdata    = halo | flip;
    cha_o    = fg;
    blk_o    = blank_only_i ? bdata : (bdata | fg);
  end
endmodule

// File: rtl/osd_mix_top.sv
module osd_mix_top
  import osd_mix_pkg::*;
#(
  parameter int LINE_PIX  = 320,
  parameter int ROWS      = 12,
  parameter int ROW_W     = 4,
  parameter int SLOW_HALF = 30,
  parameter int FAST_HALF = 15
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             font_pix_i,
  input  logic             attr_i,
  input  logic             in_grid_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             vsync_n_i,
  input  logic             dsp_i,
  input  logic             rv_i,
  input  logic             blink_en_i,
  input  logic             blink_slow_i,
  input  logic             border_en_i,
  input  logic             blank_only_i,
  input  logic             sys1_excl_i,
  input  logic [ROWS-1:0]  line_en_i,
  output logic             cha1_o,
  output logic             blk1_o,
  output logic             cha2_o,
  output logic             blk2_o
);
  localparam int CELL_W = $bits(osd_cell_t);
  localparam int TAP_W  = CELL_W + ROW_W;
  localparam int PRIME  = 2 * LINE_PIX + 2;
  localparam int PW     = $clog2(PRIME + 1);

  osd_cell_t        in_cell, right_cell, ctr_cell;
  logic [TAP_W-1:0] tap_d, tap_q, ctr_q;
  logic [ROW_W-1:0] ctr_row;
  logic             right_px, up_px, left_px, in_px, down_px;
  logic [PW-1:0]    pcnt;
  logic             primed, ctr_ingrid, row_ok, sys2_sel, sys1_sel, show;
  logic             blink_phase, cha, blk;
  logic [3:0]       nb;

  assign in_cell = '{attr: attr_i, ingrid: in_grid_i, font: font_pix_i};
  assign tap_d   = {row_i, in_cell};

  // First line memory: the full pixel record, LINE_PIX cycles late.
  osd_line_delay #(.W(TAP_W), .DEPTH(LINE_PIX)) u_dly_ctr (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (tap_d),
    .q_o   (tap_q)
  );

  assign right_cell = tap_q[CELL_W-1:0];
  assign right_px   = eff_pix(right_cell);

  // Second line memory: only the lit bit, for the neighbour above.
  osd_line_delay #(.W(1), .DEPTH(LINE_PIX)) u_dly_up (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (right_px),
    .q_o   (up_px)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ctr_q   <= '0;
      left_px <= 1'b0;
      in_px   <= 1'b0;
      down_px <= 1'b0;
      pcnt    <= '0;
    end else begin
      in_px   <= font_pix_i & in_grid_i;
      down_px <= in_px;
      ctr_q   <= tap_q;
      left_px <= eff_pix(ctr_cell);
      if (pcnt != PW'(PRIME)) pcnt <= pcnt + 1'b1;
    end
  end

  assign ctr_cell   = ctr_q[CELL_W-1:0];
  assign ctr_row    = ctr_q[TAP_W-1:CELL_W];
  assign primed     = (pcnt == PW'(PRIME));
  assign ctr_ingrid = ctr_cell.ingrid & primed;
  assign nb         = {up_px, down_px, left_px, right_px};

  osd_blink_timer #(.SLOW_HALF(SLOW_HALF), .FAST_HALF(FAST_HALF)) u_blink (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .vsync_n_i (vsync_n_i),
    .slow_i    (blink_slow_i),
    .phase_o   (blink_phase)
  );

  osd_cell_shade u_shade (
    .font_i       (eff_pix(ctr_cell)),
    .attr_i       (ctr_cell.attr),
    .phase_i      (blink_phase),
    .rv_en_i      (rv_i),
    .blink_en_i   (blink_en_i),
    .border_en_i  (border_en_i),
    .blank_only_i (blank_only_i),
    .nb_i         (nb),
    .cha_o        (cha),
    .blk_o        (blk)
  );

  // Row decode: one comparator per text row.
  always_comb begin
    row_ok   = 1'b0;
    sys2_sel = 1'b0;
    for (int i = 0; i < ROWS; i++) begin
      if (ctr_row == ROW_W'(i)) begin
        row_ok   = 1'b1;
        sys2_sel = line_en_i[i];
      end
    end
  end

  assign sys1_sel = sys1_excl_i ? ~sys2_sel : 1'b1;
  assign show     = ctr_ingrid & dsp_i & row_ok;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cha1_o <= 1'b0;
      blk1_o <= 1'b0;
      cha2_o <= 1'b0;
      blk2_o <= 1'b0;
    end else begin
      cha1_o <= show & sys1_sel & cha;
      blk1_o <= show & sys1_sel & blk;
      cha2_o <= show & sys2_sel & cha;
      blk2_o <= show & sys2_sel & blk;
    end
  end
endmodule

// File: rtl/osd_mix_chk.sv
module osd_mix_chk #(
  parameter int ROWS  = 12,
  parameter int ROW_W = 4
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             vsync_n_i,
  input logic             dsp_i,
  input logic             blank_only_i,
  input logic             sys1_excl_i,
  input logic [ROWS-1:0]  line_en_i,
  input logic             ctr_ingrid,
  input logic [ROW_W-1:0] ctr_row,
  input logic             blink_phase,
  input logic             cha1_o,
  input logic             blk1_o,
  input logic             cha2_o,
  input logic             blk2_o
);
  // R3: a pixel outside the grid drives nothing
  p_outside_dark_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(ctr_ingrid) |-> !(cha1_o || blk1_o || cha2_o || blk2_o));

  // R3: display disabled drives nothing
  p_display_off_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(dsp_i) |-> !(cha1_o || blk1_o || cha2_o || blk2_o));

  // R10: in the mixed blank mode the foreground is always keyed
  p_blank_keys_char_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(blank_only_i) |-> ((!cha1_o || blk1_o) && (!cha2_o || blk2_o)));

  // R11: channel two only for enabled rows
  p_sys2_row_enabled_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    (cha2_o || blk2_o) |-> ((($past(line_en_i) >> $past(ctr_row)) & ROWS'(1)) != '0));

  // R12: exclusive mode never shows a pixel on both channels
  p_excl_disjoint_r12: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(sys1_excl_i) |-> (!(cha1_o && cha2_o) && !(blk1_o && blk2_o)));

  // R8: the blink phase moves only right after a sync fall
  p_phase_on_fall_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(blink_phase) |-> ($past(vsync_n_i, 2) && !$past(vsync_n_i)));
endmodule

bind osd_mix_top osd_mix_chk #(.ROWS(ROWS), .ROW_W(ROW_W)) u_chk (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .vsync_n_i    (vsync_n_i),
  .dsp_i        (dsp_i),
  .blank_only_i (blank_only_i),
  .sys1_excl_i  (sys1_excl_i),
  .line_en_i    (line_en_i),
  .ctr_ingrid   (ctr_ingrid),
  .ctr_row      (ctr_row),
  .blink_phase  (blink_phase),
  .cha1_o       (cha1_o),
  .blk1_o       (blk1_o),
  .cha2_o       (cha2_o),
  .blk2_o       (blk2_o)
);

// File: tb/tb_osd_mix_top.sv
`timescale 1ns/1ps
module tb_osd_mix_top;
  localparam int N     = 8;
  localparam int ROWS  = 12;
  localparam int ROW_W = 4;
  localparam int LAT   = N + 2;
  localparam int PRIME = 2 * N + 2;
  localparam int MAXE  = 4096;
  localparam int CYC   = 10 * N;
  localparam int NV    = 12;

  typedef struct packed {
    logic [11:0] len;
    logic        slow, excl, bonly, eg, bk, rv, dsp;
    logic [5:0]  fields;
    logic [7:0]  seed;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{12'hFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 6'd0,  8'd1},
    '{12'hFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 6'd0,  8'd2},
    '{12'hFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 6'd15, 8'd3},
    '{12'hFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 6'd0,  8'd4},
    '{12'hFFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 6'd0,  8'd5},
    '{12'hFFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 6'd0,  8'd6},
    '{12'hA5C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 6'd0,  8'd7},
    '{12'h3F0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 6'd0,  8'd8},
    '{12'hFFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 6'd30, 8'd9},
    '{12'hFFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 6'd0,  8'd10},
    '{12'hFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 6'd14, 8'd11},
    '{12'hFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 6'd1,  8'd12}
  };

  function automatic string req_of(int i);
    case (i)
      0:       return "R4";
      1:       return "R5";
      2:       return "R6";
      3:       return "R7";
      4:       return "R9";
      5:       return "R10";
      6:       return "R11";
      7:       return "R12";
      8:       return "R8";
      9:       return "R3";
      default: return "R8";
    endcase
  endfunction

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_i = 1'b1;
  logic             font_pix_i = 1'b0, attr_i = 1'b0, in_grid_i = 1'b0;
  logic [ROW_W-1:0] row_i = '0;
  logic             vsync_n_i = 1'b1;
  logic             dsp_i = 1'b0, rv_i = 1'b0, blink_en_i = 1'b0, blink_slow_i = 1'b0;
  logic             border_en_i = 1'b0, blank_only_i = 1'b0, sys1_excl_i = 1'b0;
  logic [ROWS-1:0]  line_en_i = '0;
  logic             cha1_o, blk1_o, cha2_o, blk2_o;

  osd_mix_top #(.LINE_PIX(N), .ROWS(ROWS), .ROW_W(ROW_W)) dut (
    .clk_i(clk), .rst_i(rst_i), .font_pix_i(font_pix_i), .attr_i(attr_i),
    .in_grid_i(in_grid_i), .row_i(row_i), .vsync_n_i(vsync_n_i), .dsp_i(dsp_i),
    .rv_i(rv_i), .blink_en_i(blink_en_i), .blink_slow_i(blink_slow_i),
    .border_en_i(border_en_i), .blank_only_i(blank_only_i),
    .sys1_excl_i(sys1_excl_i), .line_en_i(line_en_i),
    .cha1_o(cha1_o), .blk1_o(blk1_o), .cha2_o(cha2_o), .blk2_o(blk2_o)
  );

  int compared = 0;
  int mismatched = 0;
  int E = 0;
  string cur_req = "R1";
  logic [7:0] seed = 8'd0;

  logic        h_font [MAXE];
  logic        h_attr [MAXE];
  logic        h_ing  [MAXE];
  int          h_row  [MAXE];
  logic [18:0] h_ctl  [MAXE];
  logic        h_rst  [MAXE];
  logic        h_ph   [MAXE];
  int          h_pc   [MAXE];

  logic m_vsd = 1'b0, m_ph = 1'b0;
  int   m_cnt = 0;

  function automatic logic lit(int j);
    if (j < 1) return 1'b0;
    return h_font[j] & h_ing[j];
  endfunction

  // Expected output word {cha1, blk1, cha2, blk2} after edge e, from the requirements.
  function automatic logic [3:0] expect_at(int e);
    int k;
    logic [18:0] c;
    logic px, rev, bl, hide, flip, fg, halo, bd, bo, s1, s2;
    k = e - LAT;
    c = h_ctl[e];
    if (h_rst[e]) return 4'b0;                         // R1
    if (h_pc[e-1] != PRIME) return 4'b0;               // R1 fill time
    if (k < 1) return 4'b0;
    if (!h_ing[k] || !c[0] || h_row[k] >= ROWS) return 4'b0;  // R3, R11
    px   = lit(k);
    rev  = h_attr[k] & c[1];
    bl   = h_attr[k] & c[2];
    hide = bl & !rev & h_ph[e-1];
    flip = rev & !(bl & h_ph[e-1]);
    fg   = hide ? 1'b0 : (flip ? !px : px);
    halo = c[3] & !px & (lit(k-1) | lit(k+1) | lit(k-N) | lit(k+N)) & !hide;
    bd   = halo | flip;
    bo   = c[4] ? bd : (bd | fg);
    s2   = c[7 + h_row[k]];
    s1   = c[5] ? !s2 : 1'b1;
    return {s1 & fg, s1 & bo, s2 & fg, s2 & bo};
  endfunction

  task automatic step(input logic vs);
    int k;
    logic [31:0] v;
    logic [3:0] got, exp;
    int lim;
    k = E + 1;
    v = ((32'(k) * 32'd1103515245) ^ (32'(seed) * 32'd2654435761)) + 32'd12345;
    font_pix_i = v[15];
    attr_i     = v[22];
    in_grid_i  = ((k % N) != 0) && ((k % N) != N - 1);
    row_i      = ROW_W'((k / N) % 14);
    vsync_n_i  = vs;
    @(posedge clk);
    E = E + 1;
    h_font[E] = font_pix_i;
    h_attr[E] = attr_i;
    h_ing[E]  = in_grid_i;
    h_row[E]  = int'(row_i);
    h_ctl[E]  = {line_en_i, blink_slow_i, sys1_excl_i, blank_only_i,
                 border_en_i, blink_en_i, rv_i, dsp_i};
    h_rst[E]  = rst_i;
    if (rst_i) begin
      m_vsd = 1'b0; m_cnt = 0; m_ph = 1'b0;
      h_pc[E] = 0;
    end else begin
      if (m_vsd && !vs) begin                           // R8
        lim = blink_slow_i ? 30 : 15;
        if (m_cnt >= lim - 1) begin
          m_cnt = 0;
          m_ph  = !m_ph;
        end else begin
          m_cnt = m_cnt + 1;
        end
      end
      m_vsd = vs;
      h_pc[E] = (h_pc[E-1] < PRIME) ? h_pc[E-1] + 1 : PRIME;
    end
    h_ph[E] = m_ph;
    #1;
    got = {cha1_o, blk1_o, cha2_o, blk2_o};
    exp = expect_at(E);
    compared = compared + 1;
    if (got !== exp) begin
      mismatched = mismatched + 1;
      $display("FAIL %s cycle %0d: got %b expected %b", cur_req, E, got, exp);
    end
  endtask

  task automatic load(input vec_t t);
    line_en_i    = t.len;
    blink_slow_i = t.slow;
    sys1_excl_i  = t.excl;
    blank_only_i = t.bonly;
    border_en_i  = t.eg;
    blink_en_i   = t.bk;
    rv_i         = t.rv;
    dsp_i        = t.dsp;
    seed         = t.seed;
  endtask

  initial begin
    h_pc[0] = 0; h_ph[0] = 1'b0; h_rst[0] = 1'b1;
    // R1: outputs low in reset and during the fill time
    cur_req = "R1";
    load(VECS[0]);
    rst_i = 1'b1;
    repeat (3) step(1'b1);
    rst_i = 1'b0;
    repeat (3 * N) step(1'b1);

    for (int i = 0; i < NV; i++) begin
      load(VECS[i]);
      cur_req = req_of(i);
      for (int f = 0; f < int'(VECS[i].fields); f++) begin
        step(1'b0);
        step(1'b1);
      end
      repeat (CYC) step(1'b1);
    end

    // R2: plain stream, outputs must trail the input by LINE_PIX+2 edges
    cur_req = "R2";
    load(VECS[0]);
    seed = 8'd77;
    repeat (CYC) step(1'b1);

    // R1: mid-run reset clears outputs and the blink phase
    cur_req = "R1";
    load(VECS[2]);
    rst_i = 1'b1;
    repeat (2) step(1'b1);
    rst_i = 1'b0;
    repeat (3 * N + CYC) step(1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(20000 * 5);
    mismatched = mismatched + 1;
    compared = compared + 1;
    $display("FAIL R2 watchdog: got no completion expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule